// File: doc/BRIEF.md
# Enhanced Feature Control Unit

This unit holds an 8-bit feature-control register for a serial port and carries out three of its functions. First, one lock bit decides whether the CPU may change the enhanced fields that live in the interrupt-enable, FIFO-control and modem-control registers. Second, a comparator checks every received character against a programmed special character. A match raises a sticky flag, and the character still goes on to the receive queue. Third, an optional clear-to-send gate lets the transmitter begin a new character only while the synchronized active-low CTS pin is low.

The CPU reaches the unit through a simple register bus. A write strobe, a read strobe and an address form the bus. Read data is combinational. A read of the interrupt-status address clears the special-character flag. The transmitter raises `tx_req` only at a character boundary, when it has a character waiting. The unit answers with `tx_start`, so a character that is already being sent always finishes. The four soft flow-control mode bits are only stored and passed on through a port.

Top module: `feat_ctrl`

## Requirements
- R1: After reset, every register address reads 0. The enhanced outputs and `sc_flag` are 0. `tx_start` follows `tx_req`. The address map is: 0 feature register, 1 IER, 2 FCR, 3 MCR, 4 special-character register, 5 interrupt status. Addresses 6 and 7 read 0.
- R2: While feature bit 4 (the unlock bit) is 0, writes to IER bits 7:4, FCR bits 5:4 and MCR bits 7:5 are ignored. These fields keep their values on both the readback and the `ier_enh`/`fcr_enh`/`mcr_enh` outputs.
- R3: While feature bit 4 is 1, a write to address 1, 2 or 3 loads the enhanced field at the next clock edge. After bit 4 is cleared, the loaded values are held. All other bits of addresses 1 to 3 read 0.
- R4: Feature bit 5 enables detection. While it is 1 and feature bits 3:0 are 0, a `rx_valid` cycle with `rx_data` equal to the special-character register sets interrupt-status bit 4 and `sc_flag` at the next edge. Data bit 0 corresponds to register bit 0.
- R5: Every received character goes to `rxq_wr`/`rxq_data` in the same cycle, whether or not it matches.
- R6: The flag stays set until a read of address 5, which clears it at that edge. If a new match arrives in the same cycle as the read, the flag stays set.
- R7: If feature bits 3:0 are not all 0, no match sets the flag.
- R8: While feature bit 7 is 1 and the synchronized `cts_n` is 1, `tx_start` is 0. In all other cases, `tx_start` equals `tx_req`.
- R9: `cts_n` passes through a two-flop synchronizer. A change of `cts_n` reaches the gate after two rising edges. The synchronizer resets to the halted level (1).
- R10: The feature register (all 8 bits, with bits 3:0 also output on `sw_fc_mode`) and the special-character register can always be written and read back. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag at address 5) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character, bit 0 first received |
| rxq_wr | output | 1 | Receive queue write strobe |
| rxq_data | output | 8 | Character forwarded to the receive queue |
| tx_req | input | 1 | Transmitter has a character ready at a boundary |
| tx_start | output | 1 | Permission to start that character |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |
| ier_enh | output | 4 | Enhanced IER bits 7:4 |
| fcr_enh | output | 2 | Enhanced FCR bits 5:4 |
| mcr_enh | output | 3 | Enhanced MCR bits 7:5 |
| sw_fc_mode | output | 4 | Stored soft flow-control mode bits |
| sc_flag | output | 1 | Special-character detected flag |

## Verification
The register writes use unlock values that are on, off, and toggled between writes. This shows whether the gate samples the lock bit before or after a write in the same cycle. The received characters mix forced matches with random values, and the detection and mode bits are set in every combination. This separates a correct comparator from one that ignores the enable, ignores the mode guard, or loses a match that arrives together with a clearing read. The CTS pin toggles slowly while `tx_req` is held. This exposes a synchronizer that is too short or too long, and it checks that the gate is open whenever auto-CTS is off.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int CHAR_W    = 8;
    localparam int ADR_W     = 3;
    localparam int IER_ENH_W = 4;
    localparam int FCR_ENH_W = 2;
    localparam int MCR_ENH_W = 3;
    localparam int MODE_W    = 4;

    localparam logic [ADR_W-1:0] ADR_FEAT  = 3'd0;
    localparam logic [ADR_W-1:0] ADR_IER   = 3'd1;
    localparam logic [ADR_W-1:0] ADR_FCR   = 3'd2;
    localparam logic [ADR_W-1:0] ADR_MCR   = 3'd3;
    localparam logic [ADR_W-1:0] ADR_SCHR  = 3'd4;
    localparam logic [ADR_W-1:0] ADR_ISTAT = 3'd5;

    localparam int B_UNLOCK = 4;
    localparam int B_DETECT = 5;
    localparam int B_CTS    = 7;
    localparam int B_FLAG   = 4;

    typedef struct packed {
        logic [CHAR_W-1:0]    feat;
        logic [IER_ENH_W-1:0] ier;
        logic [FCR_ENH_W-1:0] fcr;
        logic [MCR_ENH_W-1:0] mcr;
        logic [CHAR_W-1:0]    schr;
    } regs_t;

    typedef struct packed {
        logic flag;
    } det_t;
endpackage

// File: rtl/fe_regs.sv
module fe_regs
    import fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADR_W-1:0]     addr,
    input  logic [CHAR_W-1:0]    wdata,
    input  logic                 flag,
    output logic [CHAR_W-1:0]    rdata,
    output logic                 clr_flag,
    output logic                 cts_en,
    output logic                 det_en,
    output logic [MODE_W-1:0]    mode,
    output logic [CHAR_W-1:0]    schr,
    output logic [IER_ENH_W-1:0] ier_enh,
    output logic [FCR_ENH_W-1:0] fcr_enh,
    output logic [MCR_ENH_W-1:0] mcr_enh
);
    localparam int IER_LO = CHAR_W - IER_ENH_W;
    localparam int MCR_LO = CHAR_W - MCR_ENH_W;
    localparam int FCR_LO = 4;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (addr)
                ADR_FEAT: d.feat = wdata;
                ADR_IER:  if (q.feat[B_UNLOCK]) d.ier = wdata[CHAR_W-1:IER_LO];
                ADR_FCR:  if (q.feat[B_UNLOCK]) d.fcr = wdata[FCR_LO+FCR_ENH_W-1:FCR_LO];
                ADR_MCR:  if (q.feat[B_UNLOCK]) d.mcr = wdata[CHAR_W-1:MCR_LO];
                ADR_SCHR: d.schr = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_FEAT:  rdata = q.feat;
            ADR_IER:   rdata[CHAR_W-1:IER_LO] = q.ier;
            ADR_FCR:   rdata[FCR_LO+FCR_ENH_W-1:FCR_LO] = q.fcr;
            ADR_MCR:   rdata[CHAR_W-1:MCR_LO] = q.mcr;
            ADR_SCHR:  rdata = q.schr;
            ADR_ISTAT: rdata[B_FLAG] = flag;
            default:   rdata = '0;
        endcase
    end

    assign clr_flag = rd_en && (addr == ADR_ISTAT);
    assign cts_en   = q.feat[B_CTS];
    assign det_en   = q.feat[B_DETECT];
    assign mode     = q.feat[MODE_W-1:0];
    assign schr     = q.schr;
    assign ier_enh  = q.ier;
    assign fcr_enh  = q.fcr;
    assign mcr_enh  = q.mcr;

    // R2: locked enhanced fields never move
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !q.feat[B_UNLOCK] |=> ($stable(ier_enh) && $stable(fcr_enh) && $stable(mcr_enh)));

    // R3: an unlocked IER write lands at the next edge
    a_r3_unlocked_ier: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_IER && q.feat[B_UNLOCK]) |=> (ier_enh == $past(wdata[CHAR_W-1:IER_LO])));
endmodule

// File: rtl/fe_schar.sv
module fe_schar
    import fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              det_en,
    input  logic [MODE_W-1:0] mode,
    input  logic [CHAR_W-1:0] schr,
    input  logic              clr_flag,
    output logic              flag,
    output logic              rxq_wr,
    output logic [CHAR_W-1:0] rxq_data
);
    det_t q, d;
    logic hit;

    assign hit = rx_valid && det_en && (mode == '0) && (rx_data == schr);

    always_comb begin
        d = q;
        if (clr_flag) d.flag = 1'b0;
        if (hit)      d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag     = q.flag;
    assign rxq_wr   = rx_valid;
    assign rxq_data = rx_data;

    // R4: a qualified match sets the flag
    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && det_en && mode == '0 && rx_data == schr) |=> flag);

    // R6: flag holds until a clearing read
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);

    // R7: a soft flow-control mode blocks detection
    a_r7_no_flag_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != '0) |=> !$rose(flag));
endmodule

// File: rtl/fe_ctsgate.sv
module fe_ctsgate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic cts_en,
    input  logic tx_req,
    output logic tx_start
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb sync_d = cts_n;
        end else begin : g_chain
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], cts_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign tx_start = tx_req && !(cts_en && sync_q[SYNC_STAGES-1]);

    // R8: no start without a request
    a_r8_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_req);
endmodule

// File: rtl/feat_ctrl.sv
module feat_ctrl
    import fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADR_W-1:0]     addr,
    input  logic [CHAR_W-1:0]    wdata,
    output logic [CHAR_W-1:0]    rdata,
    input  logic                 rx_valid,
    input  logic [CHAR_W-1:0]    rx_data,
    output logic                 rxq_wr,
    output logic [CHAR_W-1:0]    rxq_data,
    input  logic                 tx_req,
    output logic                 tx_start,
    input  logic                 cts_n,
    output logic [IER_ENH_W-1:0] ier_enh,
    output logic [FCR_ENH_W-1:0] fcr_enh,
    output logic [MCR_ENH_W-1:0] mcr_enh,
    output logic [MODE_W-1:0]    sw_fc_mode,
    output logic                 sc_flag
);
    logic              clr_flag, cts_en, det_en, flag;
    logic [CHAR_W-1:0] schr;

    fe_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .flag(flag), .rdata(rdata), .clr_flag(clr_flag),
        .cts_en(cts_en), .det_en(det_en), .mode(sw_fc_mode), .schr(schr),
        .ier_enh(ier_enh), .fcr_enh(fcr_enh), .mcr_enh(mcr_enh)
    );

    fe_schar u_schar (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .det_en(det_en), .mode(sw_fc_mode), .schr(schr), .clr_flag(clr_flag),
        .flag(flag), .rxq_wr(rxq_wr), .rxq_data(rxq_data)
    );

    fe_ctsgate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .cts_en(cts_en),
        .tx_req(tx_req), .tx_start(tx_start)
    );

    assign sc_flag = flag;

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R9: a start with auto-CTS on means CTS was low two edges back
            a_r9_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_start && cts_en) |-> !$past(cts_n, 2));
        end
    endgenerate
endmodule

// File: tb/test_feat_ctrl.sv
`timescale 1ns/1ps
module test_feat_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, rx_valid = 0, tx_req = 0, cts_n = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rx_data = 0;
    logic [7:0] rdata, rxq_data;
    logic       rxq_wr, tx_start, sc_flag;
    logic [3:0] ier_enh, sw_fc_mode;
    logic [1:0] fcr_enh;
    logic [2:0] mcr_enh;

    int nchk = 0, nerr = 0;

    logic [7:0] m_feat = 0, m_sc = 0;
    logic [3:0] m_ier = 0;
    logic [1:0] m_fcr = 0;
    logic [2:0] m_mcr = 0;
    logic       m_flag = 0;
    logic [1:0] hist = 2'b11;

    always #2.5 clk = ~clk;

    feat_ctrl i_feat_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rxq_wr(rxq_wr), .rxq_data(rxq_data), .tx_req(tx_req), .tx_start(tx_start),
        .cts_n(cts_n), .ier_enh(ier_enh), .fcr_enh(fcr_enh), .mcr_enh(mcr_enh),
        .sw_fc_mode(sw_fc_mode), .sc_flag(sc_flag)
    );

    // R9: bench view of CTS two edges deep, halted level at reset
    always @(posedge clk or negedge rst_n)
        if (!rst_n) hist <= 2'b11;
        else        hist <= {hist[0], cts_n};

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_feat;
            3'd1: return {m_ier, 4'b0};
            3'd2: return {2'b0, m_fcr, 4'b0};
            3'd3: return {m_mcr, 5'b0};
            3'd4: return m_sc;
            3'd5: return {3'b0, m_flag, 4'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0, 3'd4: return "R10 readback";
            3'd1, 3'd2, 3'd3: return "R2 R3 enhanced readback";
            3'd5: return "R4 R6 status readback";
            default: return "R1 unmapped readback";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [7:0] wd,
                       input logic rv, input logic [7:0] rdv, input logic tr, input logic cn);
        logic hit, clr;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = wd;
        rx_valid = rv; rx_data = rdv; tx_req = tr; cts_n = cn;
        #1;
        if (r) chk(rd_tag(a), rdata, exp_rd(a));
        chk("R5 forward strobe", rxq_wr, rv);
        if (rv) chk("R5 forward data", rxq_data, rdv);
        chk("R8 R9 tx gate", tx_start, tr && !(m_feat[7] && hist[1]));
        chk("R2 R3 enhanced outputs", {ier_enh, fcr_enh, mcr_enh}, {m_ier, m_fcr, m_mcr});
        chk("R6 flag output", sc_flag, m_flag);
        chk("R10 mode output", sw_fc_mode, m_feat[3:0]);
        @(posedge clk);
        hit = rv && m_feat[5] && (m_feat[3:0] == 4'd0) && (rdv == m_sc);
        clr = r && (a == 3'd5);
        m_flag = (m_flag && !clr) || hit;
        if (w) begin
            case (a)
                3'd1: if (m_feat[4]) m_ier = wd[7:4];
                3'd2: if (m_feat[4]) m_fcr = wd[5:4];
                3'd3: if (m_feat[4]) m_mcr = wd[7:5];
                3'd4: m_sc = wd;
                3'd0: m_feat = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, 0, tx_req, cts_n);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(0, 1, a, 0, 0, 0, tx_req, cts_n);
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        tx_req = 1; cts_n = 1;
        #1;
        // R1: reset state
        chk("R1 reset flag", sc_flag, 0);
        chk("R1 reset enhanced", {ier_enh, fcr_enh, mcr_enh, sw_fc_mode}, 0);
        chk("R1 reset tx follows req", tx_start, 1);
        rst_n = 1;
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R2: locked writes ignored
        wr(3'd1, 8'hF0); wr(3'd2, 8'h30); wr(3'd3, 8'hE0);
        rd(3'd1); rd(3'd2); rd(3'd3);
        // R3: unlock, write, lock, attempt overwrite
        wr(3'd0, 8'h10);
        wr(3'd1, 8'hAF); wr(3'd2, 8'hFF); wr(3'd3, 8'hBF);
        rd(3'd1); rd(3'd2); rd(3'd3);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        rd(3'd1); rd(3'd2); rd(3'd3);
        chk("R3 latched IER", ier_enh, 4'hA);
        // R10: writes to 5..7 have no effect
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); rd(3'd5); rd(3'd6);

        // R4 R5 R6: match, hold, clear
        wr(3'd4, 8'h5A); wr(3'd0, 8'h20);
        cyc(0, 0, 3'd0, 0, 1, 8'h5A, 0, 0);
        cyc(0, 0, 3'd0, 0, 1, 8'h5B, 0, 0);
        chk("R6 flag held", sc_flag, 1);
        rd(3'd5); rd(3'd5);
        chk("R6 flag cleared by read", sc_flag, 0);
        // R6: set wins over same-cycle clear
        cyc(0, 0, 3'd0, 0, 1, 8'h5A, 0, 0);
        cyc(0, 1, 3'd5, 0, 1, 8'h5A, 0, 0);
        chk("R6 set wins over clear", sc_flag, 1);
        rd(3'd5);
        // R7: mode bits nonzero block detection
        wr(3'd0, 8'h21);
        cyc(0, 0, 3'd0, 0, 1, 8'h5A, 0, 0);
        chk("R7 no flag in sw mode", sc_flag, 0);

        // R8 R9: CTS gating and synchronizer delay
        wr(3'd0, 8'h80);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 1);
        chk("R9 first cycle still open", tx_start, 1);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 1);
        chk("R9 second cycle still open", tx_start, 1);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 1);
        chk("R8 halted after sync", tx_start, 0);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 0);
        chk("R8 resumes when CTS low", tx_start, 1);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic w, r, rv, tr, cn;
            logic [2:0] a;
            logic [7:0] wd, rdv;
            w  = ($urandom % 3) == 0;
            r  = !w && ($urandom % 2);
            a  = 3'($urandom % 7);
            case ($urandom % 5)
                0: wd = 8'h20;
                1: wd = 8'h10;
                2: wd = 8'hA0;
                3: wd = 8'h80;
                default: wd = 8'($urandom);
            endcase
            rv  = $urandom % 2;
            rdv = (($urandom % 3) == 0) ? m_sc : 8'($urandom);
            tr  = $urandom % 2;
            cn  = (($urandom % 4) == 0) ? !cts_n : cts_n;
            cyc(w, r, a, wd, rv, rdv, tr, cn);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule